// File: doc/BRIEF.md
# Exception Entry Sequencer

This block is the event-entry stage of a small 32-bit RISC core. Each cycle it looks at a pending synchronous exception (with its event code), a pending external interrupt (with the vector code returned by the interrupt controller), and the core state the entry needs: program counter, stack register R15, vector base, status word, sleep state and the delay-slot flag. It decides whether the event is taken, ignored, or turned into a system reset request.

For a taken event the whole entry completes in one clock. On the next edge a single `take_event` strobe is raised and, at the same edge, the saved status, saved PC and saved stack register are loaded, the new status word and the new PC are produced, and the exception or interrupt event register gets the event code. The core loads `new_pc` and `new_sr` on that strobe and clears its sleep state. An exception that arrives while events are blocked produces a one-cycle `reset_req` pulse instead.

Status word bit positions used throughout: mode (MD) bit 30, register bank (RB) bit 29, block (BL) bit 28, FPU disable (FD) bit 15, interrupt mask level bits [7:4].

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_pending` and `irq_pending` are both high in one cycle, the exception is taken: `expevt` gets `exc_code` and `intevt` keeps its old value.
- R2: With SR bit 28 set, a pending exception whose code is not 0x1E0 raises `reset_req` for one cycle, `take_event` stays low and no saved register changes; code 0x1E0 is taken normally.
- R3: With SR bit 28 set, an interrupt is ignored unless `cpu_sleeping` is high; when sleeping it is taken.
- R4: `irq_level` always equals SR bits [7:4]; an interrupt with `irq_vec_valid` low is not taken.
- R5: On a taken event `ssr` gets SR, `sgr` gets R15, and `new_sr` is SR with bits 30, 29 and 28 set.
- R6: An exception taken with `in_delay_slot` high saves PC minus 2 in `spc` and pulses `dslot_clear` together with `take_event`.
- R7: For exception codes 0x000, 0x020 and 0x140, `new_sr` also has bit 15 cleared and bits [7:4] set to 0xF, and `new_pc` is 0xA0000000.
- R8: Exception codes 0x040 and 0x060 give `new_pc` = VBR + 0x400; every other exception code outside R7 gives VBR + 0x100.
- R9: Exception code 0x160 adds 2 to the saved PC (on top of any delay-slot rewind).
- R10: A taken interrupt loads `intevt` with `irq_vec` and gives `new_pc` = VBR + 0x600, leaving `expevt` unchanged.
- R11: An interrupt is not taken while `in_delay_slot` is high.
- R12: All outputs are zero after reset; `take_event` rises exactly one cycle after a request is accepted, and when nothing is taken every saved register, `new_pc` and `new_sr` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_pending | input | 1 | A synchronous exception is pending this cycle |
| exc_code | input | 12 | Event code of the pending exception |
| irq_pending | input | 1 | An external interrupt is requested |
| irq_vec_valid | input | 1 | Controller has a source above the current mask level |
| irq_vec | input | 12 | Interrupt event code from the controller |
| irq_level | output | 4 | Current mask level sent to the controller (SR[7:4]) |
| cpu_sleeping | input | 1 | Core is in its sleep state |
| in_delay_slot | input | 1 | Current instruction sits in a branch delay slot |
| cur_pc | input | 32 | PC of the current instruction |
| cur_r15 | input | 32 | Current stack register value |
| vbr | input | 32 | Vector base |
| sr_in | input | 32 | Current status word |
| take_event | output | 1 | One-cycle strobe: entry registers updated |
| reset_req | output | 1 | One-cycle system reset request |
| dslot_clear | output | 1 | Core must clear its delay-slot flag |
| new_pc | output | 32 | Entry PC to load on `take_event` |
| new_sr | output | 32 | Entry status word to load on `take_event` |
| ssr | output | 32 | Saved status word |
| spc | output | 32 | Saved PC |
| sgr | output | 32 | Saved stack register |
| expevt | output | 12 | Last taken exception code |
| intevt | output | 12 | Last taken interrupt code |

## Verification
The assertions take for granted that request inputs are single-cycle pulses, so an accepted event is not presented again on the cycle its strobe appears, and that `vbr`, `sr_in` and `cur_r15` sampled one edge earlier are the values the entry used. The bench drives every request for exactly one cycle and returns all request inputs low before the next one, so each strobe maps to one stimulus. It also holds `irq_vec_valid` independent of the mask level, so the no-vector case is exercised directly.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int XLEN    = 32;
  localparam int CODE_W  = 12;

  // status word fields the entry logic reads or writes
  localparam int SR_MD_BIT = 30;
  localparam int SR_RB_BIT = 29;
  localparam int SR_BL_BIT = 28;
  localparam int SR_FD_BIT = 15;
  localparam int SR_IM_LSB = 4;
  localparam int SR_IM_W   = 4;

  typedef logic [XLEN-1:0]   word_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    VK_GENERAL = 2'd0,
    VK_TLBMISS = 2'd1,
    VK_IRQ     = 2'd2,
    VK_RESET   = 2'd3
  } vec_kind_e;

  localparam code_t CODE_POWERON = 12'h000;
  localparam code_t CODE_MANUAL  = 12'h020;
  localparam code_t CODE_MULTHIT = 12'h140;
  localparam code_t CODE_TLBRD   = 12'h040;
  localparam code_t CODE_TLBWR   = 12'h060;
  localparam code_t CODE_TRAP    = 12'h160;
  localparam code_t CODE_BLOK    = 12'h1E0;

  function automatic logic is_reset_class(input code_t c);
    return (c == CODE_POWERON) || (c == CODE_MANUAL) || (c == CODE_MULTHIT);
  endfunction

  function automatic logic is_tlb_miss(input code_t c);
    return (c == CODE_TLBRD) || (c == CODE_TLBWR);
  endfunction

  // saved PC: rewind for delay slot, advance past a trap
  function automatic word_t saved_pc(input word_t pc, input logic slot,
                                     input logic trap);
    word_t v;
    v = pc;
    if (slot) v = v - word_t'(2);
    if (trap) v = v + word_t'(2);
    return v;
  endfunction

  function automatic word_t entry_sr(input word_t sr, input logic rst_class);
    word_t v;
    v = sr;
    v[SR_MD_BIT] = 1'b1;
    v[SR_RB_BIT] = 1'b1;
    v[SR_BL_BIT] = 1'b1;
    if (rst_class) begin
      v[SR_FD_BIT] = 1'b0;
      v[SR_IM_LSB +: SR_IM_W] = '1;
    end
    return v;
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic  exc_pending,
  input  code_t exc_code,
  input  logic  irq_pending,
  input  logic  irq_vec_valid,
  input  logic  blocked,
  input  logic  cpu_sleeping,
  input  logic  in_delay_slot,
  output logic  take_exc,
  output logic  take_irq,
  output logic  block_exc
);

  logic irq_eligible;
  logic irq_unmasked;

  always_comb begin
    // exceptions first; interrupts wait out a delay slot
    irq_eligible = irq_pending && !exc_pending && !in_delay_slot;
    irq_unmasked = !blocked || cpu_sleeping;
    block_exc    = exc_pending && blocked && (exc_code != CODE_BLOK);
    take_exc     = exc_pending && !block_exc;
    take_irq     = irq_eligible && irq_unmasked && irq_vec_valid;
  end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter word_t GEN_OFS  = 32'h0000_0100,
  parameter word_t TLB_OFS  = 32'h0000_0400,
  parameter word_t IRQ_OFS  = 32'h0000_0600,
  parameter word_t RESET_PC = 32'hA000_0000
) (
  input  logic      take_irq,
  input  code_t     exc_code,
  input  word_t     vbr,
  output vec_kind_e kind,
  output word_t     entry_pc
);

  always_comb begin
    if (take_irq)                     kind = VK_IRQ;
    else if (is_reset_class(exc_code)) kind = VK_RESET;
    else if (is_tlb_miss(exc_code))    kind = VK_TLBMISS;
    else                               kind = VK_GENERAL;

    unique case (kind)
      VK_RESET:   entry_pc = RESET_PC;
      VK_TLBMISS: entry_pc = vbr + TLB_OFS;
      VK_IRQ:     entry_pc = vbr + IRQ_OFS;
      default:    entry_pc = vbr + GEN_OFS;
    endcase
  end

endmodule

// File: rtl/exc_save_regs.sv
module exc_save_regs
  import exc_entry_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take_exc,
  input  logic  take_irq,
  input  logic  block_exc,
  input  logic  in_delay_slot,
  input  word_t next_spc,
  input  word_t next_sr,
  input  word_t next_pc,
  input  word_t sr_in,
  input  word_t cur_r15,
  input  code_t exc_code,
  input  code_t irq_vec,
  output logic  take_event,
  output logic  reset_req,
  output logic  dslot_clear,
  output word_t new_pc,
  output word_t new_sr,
  output word_t ssr,
  output word_t spc,
  output word_t sgr,
  output code_t expevt,
  output code_t intevt
);

  logic take;
  assign take = take_exc || take_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_event  <= 1'b0;
      reset_req   <= 1'b0;
      dslot_clear <= 1'b0;
      new_pc      <= '0;
      new_sr      <= '0;
      ssr         <= '0;
      spc         <= '0;
      sgr         <= '0;
      expevt      <= '0;
      intevt      <= '0;
    end else begin
      take_event  <= take;
      reset_req   <= block_exc;
      dslot_clear <= take && in_delay_slot;
      if (take) begin
        new_pc <= next_pc;
        new_sr <= next_sr;
        ssr    <= sr_in;
        spc    <= next_spc;
        sgr    <= cur_r15;
      end
      if (take_exc) expevt <= exc_code;
      if (take_irq) intevt <= irq_vec;
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int    XW       = XLEN,
  parameter int    CW       = CODE_W,
  parameter word_t GEN_OFS  = 32'h0000_0100,
  parameter word_t TLB_OFS  = 32'h0000_0400,
  parameter word_t IRQ_OFS  = 32'h0000_0600,
  parameter word_t RESET_PC = 32'hA000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_pending,
  input  logic [CW-1:0] exc_code,
  input  logic          irq_pending,
  input  logic          irq_vec_valid,
  input  logic [CW-1:0] irq_vec,
  output logic [3:0]    irq_level,
  input  logic          cpu_sleeping,
  input  logic          in_delay_slot,
  input  logic [XW-1:0] cur_pc,
  input  logic [XW-1:0] cur_r15,
  input  logic [XW-1:0] vbr,
  input  logic [XW-1:0] sr_in,
  output logic          take_event,
  output logic          reset_req,
  output logic          dslot_clear,
  output logic [XW-1:0] new_pc,
  output logic [XW-1:0] new_sr,
  output logic [XW-1:0] ssr,
  output logic [XW-1:0] spc,
  output logic [XW-1:0] sgr,
  output logic [CW-1:0] expevt,
  output logic [CW-1:0] intevt
);

  // internal events brought out for the checker
  logic      take_exc_w;
  logic      take_irq_w;
  logic      block_exc_w;
  logic      blocked_w;
  logic      trap_w;
  vec_kind_e kind_w;
  word_t     entry_pc_w;
  word_t     next_sr_w;
  word_t     next_spc_w;

  assign blocked_w = sr_in[SR_BL_BIT];
  assign irq_level = sr_in[SR_IM_LSB +: SR_IM_W];
  assign trap_w    = take_exc_w && (exc_code == CODE_TRAP);

  exc_arbiter u_arb (
    .exc_pending   (exc_pending),
    .exc_code      (exc_code),
    .irq_pending   (irq_pending),
    .irq_vec_valid (irq_vec_valid),
    .blocked       (blocked_w),
    .cpu_sleeping  (cpu_sleeping),
    .in_delay_slot (in_delay_slot),
    .take_exc      (take_exc_w),
    .take_irq      (take_irq_w),
    .block_exc     (block_exc_w)
  );

  exc_vector_sel #(
    .GEN_OFS (GEN_OFS),
    .TLB_OFS (TLB_OFS),
    .IRQ_OFS (IRQ_OFS),
    .RESET_PC(RESET_PC)
  ) u_vec (
    .take_irq (take_irq_w),
    .exc_code (exc_code),
    .vbr      (vbr),
    .kind     (kind_w),
    .entry_pc (entry_pc_w)
  );

  assign next_sr_w  = entry_sr(sr_in, kind_w == VK_RESET);
  assign next_spc_w = saved_pc(cur_pc, in_delay_slot, trap_w);

  exc_save_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_exc     (take_exc_w),
    .take_irq     (take_irq_w),
    .block_exc    (block_exc_w),
    .in_delay_slot(in_delay_slot),
    .next_spc     (next_spc_w),
    .next_sr      (next_sr_w),
    .next_pc      (entry_pc_w),
    .sr_in        (sr_in),
    .cur_r15      (cur_r15),
    .exc_code     (exc_code),
    .irq_vec      (irq_vec),
    .take_event   (take_event),
    .reset_req    (reset_req),
    .dslot_clear  (dslot_clear),
    .new_pc       (new_pc),
    .new_sr       (new_sr),
    .ssr          (ssr),
    .spc          (spc),
    .sgr          (sgr),
    .expevt       (expevt),
    .intevt       (intevt)
  );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  exc_pending,
  input logic  irq_pending,
  input logic  in_delay_slot,
  input logic  cpu_sleeping,
  input word_t sr_in,
  input word_t cur_r15,
  input word_t vbr,
  input logic  take_event,
  input logic  reset_req,
  input word_t new_sr,
  input word_t new_pc,
  input word_t ssr,
  input word_t sgr,
  input logic  take_irq_w,
  input logic  block_exc_w
);

  // R2: a reset request follows a pending exception while blocked
  assert_reset_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> ($past(exc_pending) && $past(sr_in[SR_BL_BIT])));

  // R2: a blocked exception never also enters
  assert_block_no_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    block_exc_w |=> !take_event);

  // R3: a blocked interrupt enters only from sleep
  assert_bl_irq_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_event && !$past(exc_pending) && $past(sr_in[SR_BL_BIT]))
      |-> $past(cpu_sleeping));

  // R5: entry mode bits set
  assert_entry_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_event |-> (new_sr[SR_MD_BIT] && new_sr[SR_RB_BIT] && new_sr[SR_BL_BIT]));

  // R5: saved status and stack register
  assert_saved_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_event |-> (ssr == $past(sr_in) && sgr == $past(cur_r15)));

  // R10: interrupt vector offset
  assert_irq_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_event && !$past(exc_pending)) |-> (new_pc == $past(vbr) + 32'h600));

  // R11: no interrupt entry from a delay slot
  assert_no_irq_in_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take_event && $past(in_delay_slot)) |-> $past(exc_pending));

  // R1: interrupt selection only with no exception pending
  assert_exc_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_w |-> (irq_pending && !exc_pending));

endmodule

bind exc_entry_seq exc_entry_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .exc_pending  (exc_pending),
  .irq_pending  (irq_pending),
  .in_delay_slot(in_delay_slot),
  .cpu_sleeping (cpu_sleeping),
  .sr_in        (sr_in),
  .cur_r15      (cur_r15),
  .vbr          (vbr),
  .take_event   (take_event),
  .reset_req    (reset_req),
  .new_sr       (new_sr),
  .new_pc       (new_pc),
  .ssr          (ssr),
  .sgr          (sgr),
  .take_irq_w   (take_irq_w),
  .block_exc_w  (block_exc_w)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_pending = 1'b0;
  logic [11:0] exc_code = '0;
  logic        irq_pending = 1'b0;
  logic        irq_vec_valid = 1'b0;
  logic [11:0] irq_vec = '0;
  logic [3:0]  irq_level;
  logic        cpu_sleeping = 1'b0;
  logic        in_delay_slot = 1'b0;
  logic [31:0] cur_pc = '0, cur_r15 = '0, vbr = '0, sr_in = '0;
  logic        take_event, reset_req, dslot_clear;
  logic [31:0] new_pc, new_sr, ssr, spc, sgr;
  logic [11:0] expevt, intevt;

  always #10 clk = ~clk;  // 50 MHz

  exc_entry_seq dut_i (.*);

  typedef struct {
    string       tag;
    bit          take, rreq, dsc;
    logic [31:0] pc, sr, ssr, spc, sgr;
    logic [11:0] expevt, intevt;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model of the held registers
  logic [31:0] m_pc = 0, m_sr = 0, m_ssr = 0, m_spc = 0, m_sgr = 0;
  logic [11:0] m_exp = 0, m_int = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // driver: apply one request for one cycle and push the expected result
  task automatic drive(string tag, bit e, logic [11:0] code, bit i, bit vv,
                       logic [11:0] iv, bit slp, bit ds, logic [31:0] sr);
    exp_t x;
    bit blk, go_e, go_i, rc;
    logic [31:0] s;
    @(negedge clk);
    exc_pending = e; exc_code = code; irq_pending = i; irq_vec_valid = vv;
    irq_vec = iv; cpu_sleeping = slp; in_delay_slot = ds; sr_in = sr;
    cur_pc = cur_pc + 32'h0000_0010; cur_r15 = cur_r15 ^ 32'h0F0F_0011;
    #1;
    chk(tag, "R4 irq_level", {28'h0, irq_level}, {28'h0, sr[7:4]});
    blk  = e && sr[28] && (code != 12'h1E0);
    go_e = e && !blk;
    go_i = !e && i && !ds && vv && (!sr[28] || slp);
    rc   = (code == 12'h000) || (code == 12'h020) || (code == 12'h140);
    if (go_e || go_i) begin
      m_ssr = sr; m_sgr = cur_r15;
      s = cur_pc;
      if (ds) s = s - 2;
      if (go_e && code == 12'h160) s = s + 2;
      m_spc = s;
      m_sr = sr | 32'h7000_0000;
      if (go_i) begin
        m_pc = vbr + 32'h600; m_int = iv;
      end else begin
        m_exp = code;
        if (rc) begin
          m_sr = (m_sr & ~32'h0000_8000) | 32'h0000_00F0;
          m_pc = 32'hA000_0000;
        end else if (code == 12'h040 || code == 12'h060) m_pc = vbr + 32'h400;
        else m_pc = vbr + 32'h100;
      end
    end
    x.tag = tag; x.take = go_e || go_i; x.rreq = blk; x.dsc = (go_e || go_i) && ds;
    x.pc = m_pc; x.sr = m_sr; x.ssr = m_ssr; x.spc = m_spc; x.sgr = m_sgr;
    x.expevt = m_exp; x.intevt = m_int;
    q.push_back(x);
    @(negedge clk);
    exc_pending = 0; irq_pending = 0; irq_vec_valid = 0; in_delay_slot = 0;
    cpu_sleeping = 0;
  endtask

  // monitor: compare after the edge that registers the request
  initial begin
    forever begin
      @(posedge clk); #5;
      if (q.size() != 0) begin
        exp_t x;
        x = q.pop_front();
        chk(x.tag, "take_event", {31'h0, take_event}, {31'h0, x.take});
        chk(x.tag, "reset_req",  {31'h0, reset_req},  {31'h0, x.rreq});
        chk(x.tag, "dslot_clear",{31'h0, dslot_clear},{31'h0, x.dsc});
        chk(x.tag, "new_pc", new_pc, x.pc);
        chk(x.tag, "new_sr", new_sr, x.sr);
        chk(x.tag, "ssr", ssr, x.ssr);
        chk(x.tag, "spc", spc, x.spc);
        chk(x.tag, "sgr", sgr, x.sgr);
        chk(x.tag, "expevt", {20'h0, expevt}, {20'h0, x.expevt});
        chk(x.tag, "intevt", {20'h0, intevt}, {20'h0, x.intevt});
        // R2 / R12: strobes last one cycle
        @(posedge clk); #5;
        chk(x.tag, "R12 strobe one cycle", {30'h0, take_event, reset_req}, 32'h0);
      end
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    vbr = 32'h8C00_0000; cur_pc = 32'h0C00_1000; cur_r15 = 32'h0CFF_FF00;
    repeat (3) @(posedge clk);
    #5;
    // R12 reset state
    chk("R12", "reset take_event", {31'h0, take_event}, 32'h0);
    chk("R12", "reset new_pc", new_pc, 32'h0);
    chk("R12", "reset ssr", ssr, 32'h0);
    chk("R12", "reset expevt", {20'h0, expevt}, 32'h0);
    @(negedge clk); rst_n = 1;

    drive("R5_R8_general",     1, 12'h180, 0, 0, 0,       0, 0, 32'h0000_00A0);
    drive("R8_tlb_read",       1, 12'h040, 0, 0, 0,       0, 0, 32'h0000_0030);
    drive("R8_tlb_write",      1, 12'h060, 0, 0, 0,       0, 0, 32'h4000_0030);
    drive("R7_reset_class",    1, 12'h140, 0, 0, 0,       0, 0, 32'h0000_8030);
    drive("R7_manual",         1, 12'h020, 0, 0, 0,       0, 0, 32'h0000_8000);
    drive("R9_trap",           1, 12'h160, 0, 0, 0,       0, 0, 32'h0000_0010);
    drive("R6_R9_trap_slot",   1, 12'h160, 0, 0, 0,       0, 1, 32'h0000_0010);
    drive("R6_slot_exc",       1, 12'h0E0, 0, 0, 0,       0, 1, 32'h0000_0020);
    drive("R10_irq",           0, 12'h000, 1, 1, 12'h3C0, 0, 0, 32'h0000_0050);
    drive("R4_no_vector",      0, 12'h000, 1, 0, 12'h3E0, 0, 0, 32'h0000_00E0);
    drive("R1_exc_over_irq",   1, 12'h100, 1, 1, 12'h400, 0, 0, 32'h0000_0000);
    drive("R2_blocked_exc",    1, 12'h180, 0, 0, 0,       0, 0, 32'h1000_0000);
    drive("R2_blocked_1e0",    1, 12'h1E0, 0, 0, 0,       0, 0, 32'h1000_0070);
    drive("R3_bl_irq_awake",   0, 12'h000, 1, 1, 12'h420, 0, 0, 32'h1000_0000);
    drive("R3_bl_irq_asleep",  0, 12'h000, 1, 1, 12'h440, 1, 0, 32'h1000_0000);
    drive("R11_irq_in_slot",   0, 12'h000, 1, 1, 12'h460, 0, 1, 32'h0000_0000);
    drive("R12_idle",          0, 12'h000, 0, 1, 12'h480, 0, 0, 32'h0000_0000);
    drive("R7_poweron",        1, 12'h000, 0, 0, 0,       0, 1, 32'h0000_8000);

    repeat (6) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule